// File: doc/BRIEF.md
# Toggle-Request RAM Load/Store Sequencer

This block turns single load and store commands into accesses on a word-wide RAM. The sequencer runs on the rising clock edge. The RAM it drives updates on the falling edge. The RAM does work only when its request input differs from an enable bit that it holds itself. It copies the request into that bit once the access is served, so it goes idle again on its own. The sequencer therefore issues each access by flipping one request bit. It also registers the write flag, the address and the write word. A store is finished one cycle after it is accepted. Load data can be used in the second cycle after acceptance.

Commands arrive on a valid/ready handshake as an operation flag, an address and a write word. Every command produces one response cycle on `rsp_done`. Load responses also raise `rsp_load` and present the word on `rsp_rdata`. Command addresses may be wider than the RAM needs, and they wrap modulo the depth. The falling-edge RAM model is instantiated inside the top module.

The controller has four states:
- `ST_IDLE`: nothing in flight.
- `ST_STORE`: the store response cycle.
- `ST_LOAD_WAIT`: the RAM is filling its output register.
- `ST_LOAD_DONE`: the load response cycle.

The transitions are:
- `ST_IDLE`, `ST_STORE` or `ST_LOAD_DONE` go to `ST_STORE` on an accepted store, to `ST_LOAD_WAIT` on an accepted load, and otherwise to `ST_IDLE`.
- `ST_LOAD_WAIT` always moves to `ST_LOAD_DONE`.

Top module: `tram_seq`

## Requirements
- R1: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_write`=1 selects a store and 0 selects a load. A load returns the word written by the most recent earlier store to the same wrapped address.
- R2: In the cycle after a store is accepted, `rsp_done`=1, `rsp_load`=0 and `cmd_ready`=1. A new command can therefore be accepted on the very next edge.
- R3: In the cycle after a load is accepted, `rsp_done`=0 and `cmd_ready`=0. In the cycle after that, `rsp_done`=1, `rsp_load`=1 and `rsp_rdata` holds the loaded word. `cmd_ready` is 1 again in that cycle.
- R4: The RAM word used is `cmd_addr` modulo `DEPTH`, including for addresses at or above `DEPTH`.
- R5: The RAM request bit changes only at an edge where a command is accepted. It flips exactly once per accepted command.
- R6: At every rising edge the RAM request bit equals the RAM enable bit, so each command causes exactly one RAM access.
- R7: During and right after reset, `cmd_ready`=1, `rsp_done`=0, and the request and enable bits are both 0.
- R8: Cycles with `cmd_valid`=0 are ignored: no response appears and the RAM contents do not change, whatever `cmd_write`, `cmd_addr` and `cmd_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; sequencer on rising edge, RAM on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | CMD_AW | Word address, wrapped modulo DEPTH |
| cmd_wdata | input | DATA_W | Store data |
| rsp_done | output | 1 | One-cycle response for every accepted command |
| rsp_load | output | 1 | Response belongs to a load |
| rsp_rdata | output | DATA_W | Loaded word, valid while rsp_load is high |

## Verification
Some rules are checked by the assertions at every rising edge:
- the RAM is idle at each edge (request bit equals enable bit);
- the request bit moves only on accepted commands;
- the one-cycle store response and the two-cycle load response follow acceptance;
- `rsp_load` never appears without `rsp_done`.

Other behaviour shows only in the bench's scenarios, which compare against a reference array:
- whether the data is correct;
- whether the modulo wrap selects the right word for every command address;
- whether idle cycles leave the memory untouched;
- whether stores interleaved with loads keep their order.

// File: rtl/tram_pkg.sv
package tram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_STORE     = 2'd1,
        ST_LOAD_WAIT = 2'd2,
        ST_LOAD_DONE = 2'd3
    } tram_state_e;

endpackage

// File: rtl/tram_addr_wrap.sv
module tram_addr_wrap #(
    parameter int CMD_AW = 16,
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [CMD_AW-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam bit IS_POW2 = ((1 << ADDR_W) == DEPTH);

    generate
        if (IS_POW2 && CMD_AW >= ADDR_W) begin : g_slice
            // R4: power-of-two depth wraps by dropping high bits
            assign addr_out = addr_in[ADDR_W-1:0];
        end else begin : g_mod
            logic [31:0] addr_mod;
            assign addr_mod = 32'(addr_in) % 32'(DEPTH);
            assign addr_out = addr_mod[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/tram_mem.sv
module tram_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en_q
);

    logic [DATA_W-1:0] words [DEPTH];
    logic              fire;

    // Work is pending only while the request differs from the held enable
    assign fire = (req != en_q);

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (fire) begin
            en_q <= req;
        end
    end

    always_ff @(negedge clk) begin
        if (fire && wr) begin
            words[addr] <= wdata;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (fire && !wr) begin
            rdata <= words[addr];
        end
    end

endmodule

// File: rtl/tram_fsm.sv
module tram_fsm
    import tram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_word,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic              rsp_load,
    output logic              ram_req,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);

    tram_state_e state_q, state_d;
    logic        accept;

    assign accept = cmd_valid && cmd_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_STORE, ST_LOAD_DONE: begin
                if (accept) begin
                    state_d = cmd_write ? ST_STORE : ST_LOAD_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOAD_WAIT: state_d = ST_LOAD_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cmd_ready = 1'b1;
        rsp_done  = 1'b0;
        rsp_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_STORE: begin
                rsp_done = 1'b1;
            end
            ST_LOAD_WAIT: begin
                cmd_ready = 1'b0;
            end
            ST_LOAD_DONE: begin
                rsp_done = 1'b1;
                rsp_load = 1'b1;
            end
            default: ;
        endcase
    end

    // Issue registers: only the accepting transitions flip the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_req   <= 1'b0;
            ram_wr    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else if (accept) begin
            ram_req   <= ~ram_req;
            ram_wr    <= cmd_write;
            ram_addr  <= cmd_word;
            ram_wdata <= cmd_wdata;
        end
    end

endmodule

// File: rtl/tram_seq.sv
module tram_seq #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int CMD_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic              rsp_load,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] cmd_word;
    logic              ram_req;
    logic              ram_wr;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_en;

    tram_addr_wrap #(
        .CMD_AW (CMD_AW),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_wrap (
        .addr_in  (cmd_addr),
        .addr_out (cmd_word)
    );

    tram_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_write (cmd_write),
        .cmd_word  (cmd_word),
        .cmd_wdata (cmd_wdata),
        .rsp_done  (rsp_done),
        .rsp_load  (rsp_load),
        .ram_req   (ram_req),
        .ram_wr    (ram_wr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    tram_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ram_req),
        .wr    (ram_wr),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata),
        .en_q  (ram_en)
    );

    assign rsp_rdata = ram_rdata;

endmodule

// File: rtl/tram_seq_chk.sv
module tram_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_write,
    input logic rsp_done,
    input logic rsp_load,
    input logic ram_req,
    input logic ram_en
);

    assert_ram_idle_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        ram_req == ram_en
    );

    assert_req_moves_on_accept_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ram_req != $past(ram_req)) |-> $past(cmd_valid && cmd_ready)
    );

    assert_store_one_cycle_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_write) |=> (rsp_done && !rsp_load && cmd_ready)
    );

    assert_load_two_cycles_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_write) |=> (!rsp_done && !cmd_ready) ##1 (rsp_done && rsp_load)
    );

    assert_load_flag_in_resp_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_load |-> rsp_done
    );

    // R7: reset state visible right after release
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R7: assert (cmd_ready && !rsp_done && !ram_req);
        end
    end

endmodule

bind tram_seq tram_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .rsp_done  (rsp_done),
    .rsp_load  (rsp_load),
    .ram_req   (ram_req),
    .ram_en    (ram_en)
);

// File: tb/tb_tram_seq.sv
`timescale 1ns/1ps
module tb_tram_seq;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 12;
    localparam int CMD_AW = 6;
    localparam int NADDR  = 1 << CMD_AW;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic              cmd_ready;
    logic              cmd_write;
    logic [CMD_AW-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              rsp_done;
    logic              rsp_load;
    logic [DATA_W-1:0] rsp_rdata;

    logic [DATA_W-1:0] model [DEPTH];
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tram_seq #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CMD_AW (CMD_AW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rsp_done  (rsp_done),
        .rsp_load  (rsp_load),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at posedge+2ns; leaves at posedge+2ns
    task automatic do_store(input int a, input logic [31:0] d);
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        cmd_addr  = CMD_AW'(a);
        cmd_wdata = d;
        check(cmd_ready == 1'b1, "R1 ready before store", 32'(cmd_ready), 32'd1);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        cmd_wdata = ~d;
        #1;
        model[a % DEPTH] = d;
        check(rsp_done == 1'b1, "R2 store done next cycle", 32'(rsp_done), 32'd1);
        check(rsp_load == 1'b0, "R2 store not a load", 32'(rsp_load), 32'd0);
        check(cmd_ready == 1'b1, "R2 ready after store", 32'(cmd_ready), 32'd1);
    endtask

    task automatic do_load(input int a, input string tag);
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        cmd_addr  = CMD_AW'(a);
        cmd_wdata = 32'hDEAD_BEEF;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        #1;
        check(rsp_done == 1'b0, "R3 no done in first load cycle", 32'(rsp_done), 32'd0);
        check(cmd_ready == 1'b0, "R3 ready low while load pending", 32'(cmd_ready), 32'd0);
        @(posedge clk);
        #2;
        check(rsp_done && rsp_load, "R3 load done in second cycle", {30'd0, rsp_done, rsp_load}, 32'd3);
        check(rsp_rdata == model[a % DEPTH], tag, rsp_rdata, model[a % DEPTH]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R7 reset state
        check(cmd_ready == 1'b1, "R7 ready after reset", 32'(cmd_ready), 32'd1);
        check(rsp_done == 1'b0, "R7 no done after reset", 32'(rsp_done), 32'd0);

        // R1/R4: back-to-back stores over every command address
        for (int a = 0; a < NADDR; a++) begin
            do_store(a, 32'hA500_0000 ^ (32'(a) * 32'h0101_0101));
        end
        // R4: each address reads the last store to its wrapped slot
        for (int a = 0; a < NADDR; a++) begin
            do_load(a, "R4 wrapped load data");
        end

        // R8: idle cycles with garbage on the command lines
        for (int i = 0; i < 6; i++) begin
            cmd_valid = 1'b0;
            cmd_write = 1'b1;
            cmd_addr  = CMD_AW'(i * 5);
            cmd_wdata = 32'hFFFF_0000 + 32'(i);
            @(posedge clk);
            #2;
            check(rsp_done == 1'b0, "R8 no response when idle", 32'(rsp_done), 32'd0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            do_load(a, "R8 memory unchanged by idle cycles");
        end

        // R5/R6: interleaved loads and stores, one access per command
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) begin
                do_store(int'(lfsr[6:1]), {lfsr, ~lfsr} ^ 32'(n));
            end else begin
                do_load(int'(lfsr[6:1]), "R6 interleaved load data");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule